// File: doc/BRIEF.md
# Manchester IR Frame Sender for a Shared Line

The block sends one 14-bit biphase remote-control frame of the RC5 kind on a line that other logic normally drives or listens to. A caller presents a 5-bit address, a 7-bit command and a toggle bit, then pulses `start`. The block first sets its pin level high while its driver is still off. It then enables the driver and holds the line high for a leading guard interval. After that it sends the 14 bits as 28 timed half-bits. Last, it holds the line high for a trailing guard interval before it releases the driver.

All timing comes from a 1 µs tick enable, so each interval is a count of ticks. The two guard gaps separate the frame from receiver traffic on the same wire. Command bit 6 selects the extended command range: it is carried inverted in the second start bit. The line level is the inverse of the logical bit value. A logical 1 is sent as a high half followed by a low half.

Top module: `manch_frame_tx`

## Requirements
- R1: After reset `line_oe` is 0, `busy` is 0 and `line_out` is 1. Whenever `busy` is 0, `line_oe` is 0 and `line_out` is 1.
- R2: When `start` is high at a clock edge while idle, `busy` goes high after that edge. For exactly one cycle `line_out` is 1 with `line_oe` still 0. On the next edge `line_oe` goes to 1.
- R3: Once `line_oe` is 1, the line stays high for `GUARD_TICKS` ticks before the first half-bit begins.
- R4: The frame bits are sent most significant first. The order is: bit 13 = 1, bit 12 = NOT cmd[6], bit 11 = toggle, bits 10..6 = addr[4:0] (addr[4] first), bits 5..0 = cmd[5:0] (cmd[5] first).
- R5: Each bit takes two halves of `HALF_TICKS` ticks each. A 1 is sent with the first half high and the second half low. A 0 is sent with the first half low and the second half high.
- R6: After the last half-bit the line is high with `line_oe` at 1 for `GUARD_TICKS` ticks. Then `line_oe` and `busy` both fall on the same edge.
- R7: A `start` pulse while `busy` is 1 is ignored. The frame in progress and its timing are unchanged, and no extra frame follows.
- R8: In any cycle where `tick` is low, `line_out` and `line_oe` keep their values, except for the `start` and preload steps of R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | 1 µs timing enable |
| start | input | 1 | Request to send a frame, taken only when idle |
| addr | input | 5 | Device address |
| cmd | input | 7 | Command; bit 6 selects the extended range |
| toggle | input | 1 | Toggle bit value placed in the frame |
| line_out | output | 1 | Level driven on the line |
| line_oe | output | 1 | Driver enable for the line |
| busy | output | 1 | High from an accepted start until the line is released |

## Verification
Frames are sent with cmd[6] both clear and set, so the inverted second start bit can be seen in both states. Toggle values of 0 and 1 and address patterns of alternating, all-ones and all-zeros bits show whether any field is shifted or swapped. Ticks arrive at an irregular rhythm, which separates counting ticks from counting clocks. A start pulse in the middle of a frame checks that it is ignored, and a start held high across the end of a frame checks the back-to-back restart timing.

// File: rtl/manch_frame_tx.sv
module manch_frame_tx #(
  parameter int GUARD_TICKS = 250000,
  parameter int HALF_TICKS  = 889
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       start,
  input  logic [4:0] addr,
  input  logic [6:0] cmd,
  input  logic       toggle,
  output logic       line_out,
  output logic       line_oe,
  output logic       busy
);
  localparam int NBITS = 14;
  localparam int MAXT  = (GUARD_TICKS > HALF_TICKS) ? GUARD_TICKS : HALF_TICKS;
  localparam int CW    = $clog2(MAXT + 1);
  localparam int IW    = $clog2(NBITS);

  typedef enum logic [2:0] {S_IDLE, S_PRE, S_LEAD, S_BITS, S_TAIL} st_t;

  st_t              st;
  logic [CW-1:0]    cnt;
  logic [NBITS-1:0] sr;
  logic [IW-1:0]    idx;
  logic             half;

  wire g_end = tick && (cnt == CW'(GUARD_TICKS - 1));
  wire h_end = tick && (cnt == CW'(HALF_TICKS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      cnt  <= '0;
      sr   <= '0;
      idx  <= '0;
      half <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          sr <= {1'b1, ~cmd[6], toggle, addr, cmd[5:0]};
          st <= S_PRE;
        end
        S_PRE: begin
          cnt <= '0;
          st  <= S_LEAD;
        end
        S_LEAD: if (tick) begin
          if (g_end) begin
            cnt  <= '0;
            idx  <= IW'(NBITS - 1);
            half <= 1'b0;
            st   <= S_BITS;
          end else cnt <= cnt + 1'b1;
        end
        S_BITS: if (tick) begin
          if (h_end) begin
            cnt <= '0;
            if (!half) half <= 1'b1;
            else begin
              half <= 1'b0;
              sr   <= sr << 1;
              if (idx == '0) st <= S_TAIL;
              else idx <= idx - 1'b1;
            end
          end else cnt <= cnt + 1'b1;
        end
        S_TAIL: if (tick) begin
          if (g_end) begin
            cnt <= '0;
            st  <= S_IDLE;
          end else cnt <= cnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy     = (st != S_IDLE);
  assign line_oe  = (st == S_LEAD) || (st == S_BITS) || (st == S_TAIL);
  assign line_out = (st == S_BITS) ? (sr[NBITS-1] ^ half) : 1'b1;

  a_r2_preload_high: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_oe) |-> line_out && $past(line_out));

  a_r2_oe_implies_busy: assert property (@(posedge clk) disable iff (!rst_n)
    line_oe |-> busy);

  a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !line_oe && line_out);

  a_r6_release_high: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(line_oe) |-> $past(line_out) && !busy);

  a_r8_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (line_oe && !tick) |=> $stable(line_out) && $stable(line_oe));

  a_r7_busy_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (line_oe && !tick) |=> busy);
endmodule

// File: tb/manch_frame_tx_test.sv
module manch_frame_tx_test;
  localparam int G = 6;
  localparam int H = 3;
  localparam int FRAME_TK = 2 * G + 28 * H;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, start = 1'b0, toggle = 1'b0;
  logic [4:0] addr = '0;
  logic [6:0] cmd = '0;
  wire line_out, line_oe, busy;

  int tests = 0, fails = 0, cyc = 0;

  always #2.5 clk = ~clk;

  manch_frame_tx #(.GUARD_TICKS(G), .HALF_TICKS(H)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start(start), .addr(addr),
    .cmd(cmd), .toggle(toggle), .line_out(line_out), .line_oe(line_oe), .busy(busy));

  int m_phase = 0, k = 0, frames = 0;
  logic [13:0] m_frame = '0;
  bit ignored = 0, tick_prev = 0;

  always @(posedge clk) begin
    tick_prev <= tick;
    if (!rst_n) begin
      m_phase = 0; k = 0; ignored = 0;
    end else begin
      case (m_phase)
        0: if (start) begin
          m_frame = {1'b1, ~cmd[6], toggle, addr, cmd[5:0]};
          m_phase = 1; ignored = 0; frames++;
        end
        1: begin m_phase = 2; k = 0; if (start) ignored = 1; end
        default: begin
          if (start) ignored = 1;
          if (tick) k++;
          if (k == FRAME_TK) m_phase = 0;
        end
      endcase
    end
  end

  function automatic string tag_of();
    int j;
    if (!rst_n || m_phase == 0) return "R1 idle/reset";
    if (m_phase == 1) return "R2 preload";
    if (ignored) return "R7 start ignored while busy";
    if (!tick_prev) return "R8 hold without tick";
    if (k < G) return "R3 leading guard";
    if (k < G + 28 * H) begin
      j = (k - G) / H;
      return (j % 2 == 0) ? "R4 bit value/order" : "R5 second half";
    end
    return "R6 trailing guard";
  endfunction

  always @(negedge clk) begin
    logic eb, eo, eout;
    int j;
    cyc++;
    if (m_phase == 0) begin eb = 0; eo = 0; eout = 1; end
    else if (m_phase == 1) begin eb = 1; eo = 0; eout = 1; end
    else begin
      eb = 1; eo = 1;
      if (k >= G && k < G + 28 * H) begin
        j = (k - G) / H;
        eout = m_frame[13 - j / 2] ^ (j % 2 == 1);
      end else eout = 1;
    end
    tests++;
    if (busy !== eb || line_oe !== eo || line_out !== eout) begin
      fails++;
      $display("FAIL %s cyc=%0d: busy/oe/out actual=%b%b%b expected=%b%b%b",
               tag_of(), cyc, busy, line_oe, line_out, eb, eo, eout);
    end
    tick <= (cyc % 5 != 2) && (cyc % 7 != 3);
  end

  task automatic wait_idle();
    while (busy === 1'b1) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic send(input logic [4:0] a, input logic [6:0] c, input logic t);
    @(negedge clk);
    addr = a; cmd = c; toggle = t; start = 1;
    @(negedge clk);
    start = 0;
    repeat (2) @(negedge clk);
    wait_idle();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    send(5'h15, 7'h2A, 1'b0);
    send(5'h0A, 7'h55, 1'b1);
    send(5'h1F, 7'h7F, 1'b1);
    send(5'h00, 7'h00, 1'b0);
    // R7: start pulse in the middle of a frame with different data
    @(negedge clk);
    addr = 5'h13; cmd = 7'h41; toggle = 0; start = 1;
    @(negedge clk); start = 0;
    repeat (60) @(negedge clk);
    addr = 5'h0C; cmd = 7'h1E; toggle = 1; start = 1;
    @(negedge clk); start = 0;
    wait_idle();
    // back-to-back: start held across the end of a frame
    addr = 5'h05; cmd = 7'h39; toggle = 1; start = 1;
    repeat (3) @(negedge clk);
    while (busy === 1'b1) @(negedge clk);
    repeat (2) @(negedge clk);
    start = 0;
    wait_idle();
    // mid-frame reset returns to R1 state
    send(5'h11, 7'h03, 1'b0);
    @(negedge clk); addr = 5'h1A; cmd = 7'h6C; start = 1;
    @(negedge clk); start = 0;
    repeat (40) @(negedge clk);
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    tests++;
    if (frames < 8) begin
      fails++;
      $display("FAIL R2 frames started actual=%0d expected>=8", frames);
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule